// File: doc/BRIEF.md
# SPI Master with DMA-Fed Transmit Path

This block is a serial peripheral master that only transmits. A memory-side DMA controller feeds it through a request/acknowledge handshake. Words land in a small internal FIFO. A start strobe loads a word count and a clock divider. While words are still owed and the FIFO has a free slot, the block keeps its DMA request raised. Every acknowledged word goes into the FIFO and lowers the count by one. Once the count reaches zero, no further requests are made.

The serial engine pulls a word from the FIFO only when one is present. When the FIFO runs dry it waits with the serial clock held low, so the line can never underrun. Words go out in SPI mode 0, most significant bit first. Each half period of the serial clock lasts `div + 1` system clocks.

Chip select goes active the cycle after an accepted start. It stays active until the last owed word has been fully shifted out. At that point it is released and a one-cycle done pulse is given. A CPU write strobe aimed at the transmit data register while a session is active counts as misuse. The block flags it and never transmits the written value.

Top module: `spi_txdma_master`

## Requirements
- R1: While a session is active, words are still owed and the FIFO (4 words of 16 bits) is not full, `dma_req_o` is high.
- R2: Each cycle with `dma_req_o` and `dma_ack_i` both high stores `dma_data_i` and lowers the remaining count by one. Once it reaches zero, `dma_req_o` stays low, so a session accepts exactly the loaded count.
- R3: Every accepted word is transmitted in acceptance order, MSB first, in mode 0: SCLK idles low, MOSI is stable at each rising SCLK edge, and each SCLK high phase lasts `div_i + 1` clocks, with `div_i` sampled at the start.
- R4: A serial word starts only when the FIFO holds data. With no accepted word left untransmitted, SCLK stays low and no error of any kind is raised.
- R5: `cs_n_o` is low from the cycle after an accepted start until every owed word has been sent. It rises in the same cycle as a single one-cycle `done_o` pulse.
- R6: A start with a count of zero is ignored: no request, no chip select and no done pulse.
- R7: A start strobe while a session is active is ignored. The loaded count and divider are unchanged.
- R8: `cpu_wr_i` high while `cs_n_o` is low raises `misuse_o` for one cycle in the next cycle, and the write never reaches MOSI. Outside a session, `misuse_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe; loads count and divider when idle |
| count_i | input | 16 | Number of words to fetch and send |
| div_i | input | 8 | SCLK half period minus one, in system clocks |
| dma_req_o | output | 1 | DMA read request |
| dma_ack_i | input | 1 | DMA acknowledge; data valid with it |
| dma_data_i | input | 16 | Word delivered by the DMA controller |
| cpu_wr_i | input | 1 | CPU write strobe to the transmit data register |
| misuse_o | output | 1 | Pulse: CPU write during an active session |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| cs_n_o | output | 1 | Active-low chip select |
| done_o | output | 1 | One-cycle pulse at session end |

## Verification
Two things can land in the same cycle. The serial engine can pop a word in the very cycle the DMA side pushes one. The session-end test can also line up with the acceptance of the final owed word. Both cases are provoked with slow acknowledge spacing, which starves the FIFO so that each arriving word is popped at once, and with back-to-back acknowledges at the smallest divider, which fill the FIFO completely. A behavioural model in the bench tracks accepted and completed words every clock. From those counts it bounds the FIFO occupancy and requires the request, chip select, done and SCLK to agree. The bench then rebuilds each word from MOSI and compares it against the accepted sequence.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic {
    SH_WAIT  = 1'b0,
    SH_SHIFT = 1'b1
  } sh_state_e;
endpackage

// File: rtl/txdma_fifo.sv
module txdma_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_i) wptr_d = bump(wptr_q);
    if (pop_i)  rptr_d = bump(rptr_q);
    case ({push_i, pop_i})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  assign data_o  = mem_q[rptr_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && full_o)); // R1
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_i && empty_o)); // R4
endmodule

// File: rtl/txdma_req_ctrl.sv
module txdma_req_ctrl #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             dma_ack_i,
  input  logic             fifo_full_i,
  input  logic             drained_i,
  input  logic             cpu_wr_i,
  output logic             dma_req_o,
  output logic             accept_o,
  output logic             sess_o,
  output logic [DIV_W-1:0] div_o,
  output logic             done_o,
  output logic             misuse_o
);
  logic             sess_q, sess_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             done_q, done_d;
  logic             mis_q, mis_d;

  assign dma_req_o = sess_q && (rem_q != '0) && !fifo_full_i;
  assign accept_o  = dma_req_o && dma_ack_i;

  always_comb begin
    sess_d = sess_q;
    rem_d  = rem_q;
    div_d  = div_q;
    done_d = 1'b0;
    mis_d  = cpu_wr_i && sess_q;
    if (!sess_q) begin
      if (start_i && (count_i != '0)) begin
        sess_d = 1'b1;
        rem_d  = count_i;
        div_d  = div_i;
      end
    end else begin
      if (accept_o) rem_d = rem_q - 1'b1;
      if ((rem_q == '0) && drained_i) begin
        sess_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q <= 1'b0;
      rem_q  <= '0;
      div_q  <= '0;
      done_q <= 1'b0;
      mis_q  <= 1'b0;
    end else begin
      sess_q <= sess_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      done_q <= done_d;
      mis_q  <= mis_d;
    end
  end

  assign sess_o   = sess_q;
  assign div_o    = div_q;
  assign done_o   = done_q;
  assign misuse_o = mis_q;

  AST_COUNT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !accept_o); // R2
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && sess_q) |=> (rem_q == $past(rem_q) - 1'b1)); // R2
endmodule

// File: rtl/txdma_shifter.sv
module txdma_shifter
  import txdma_pkg::*;
#(
  parameter int W     = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sess_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             empty_i,
  input  logic [W-1:0]     data_i,
  output logic             pop_o,
  output logic             idle_o,
  output logic             sclk_o,
  output logic             mosi_o
);
  localparam int BW = $clog2(W);

  sh_state_e        state_q, state_d;
  logic [W-1:0]     sreg_q, sreg_d;
  logic [BW-1:0]    bit_q, bit_d;
  logic [DIV_W-1:0] divc_q, divc_d;
  logic             sclk_q, sclk_d;

  always_comb begin
    state_d = state_q;
    sreg_d  = sreg_q;
    bit_d   = bit_q;
    divc_d  = divc_q;
    sclk_d  = sclk_q;
    pop_o   = 1'b0;
    case (state_q)
      SH_WAIT: begin
        sclk_d = 1'b0;
        if (sess_i && !empty_i) begin
          pop_o   = 1'b1;
          sreg_d  = data_i;
          bit_d   = '0;
          divc_d  = '0;
          state_d = SH_SHIFT;
        end
      end
      default: begin
        if (divc_q == div_i) begin
          divc_d = '0;
          if (!sclk_q) begin
            sclk_d = 1'b1;
          end else begin
            sclk_d = 1'b0;
            if (bit_q == BW'(W - 1)) begin
              state_d = SH_WAIT;
            end else begin
              bit_d  = bit_q + 1'b1;
              sreg_d = {sreg_q[W-2:0], 1'b0};
            end
          end
        end else begin
          divc_d = divc_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_WAIT;
      sreg_q  <= '0;
      bit_q   <= '0;
      divc_q  <= '0;
      sclk_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      sreg_q  <= sreg_d;
      bit_q   <= bit_d;
      divc_q  <= divc_d;
      sclk_q  <= sclk_d;
    end
  end

  assign idle_o = (state_q == SH_WAIT);
  assign sclk_o = sclk_q;
  assign mosi_o = (state_q == SH_SHIFT) && sreg_q[W-1];

  AST_MODE0_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi_o)); // R3
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_WAIT) |-> !sclk_q); // R4
endmodule

// File: rtl/spi_txdma_master.sv
module spi_txdma_master #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 16,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             dma_req_o,
  input  logic             dma_ack_i,
  input  logic [W-1:0]     dma_data_i,
  input  logic             cpu_wr_i,
  output logic             misuse_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_n_o,
  output logic             done_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             accept, pop, full, empty, idle, sess;
  logic [W-1:0]     head;
  logic [DIV_W-1:0] div_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  txdma_req_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start_i(start_i), .count_i(count_i),
    .div_i(div_i), .dma_ack_i(dma_ack_i), .fifo_full_i(full),
    .drained_i(empty && idle), .cpu_wr_i(cpu_wr_i), .dma_req_o(dma_req_o),
    .accept_o(accept), .sess_o(sess), .div_o(div_lat), .done_o(done_o),
    .misuse_o(misuse_o)
  );

  txdma_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push_i(accept), .data_i(dma_data_i),
    .pop_i(pop), .data_o(head), .full_o(full), .empty_o(empty)
  );

  txdma_shifter #(.W(W), .DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .sess_i(sess), .div_i(div_lat),
    .empty_i(empty), .data_i(head), .pop_o(pop), .idle_o(idle),
    .sclk_o(sclk_o), .mosi_o(mosi_o)
  );

  assign cs_n_o = !sess;

  AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    cs_n_o |-> (!sclk_o && !dma_req_o)); // R5
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> (cs_n_o && !$past(cs_n_o))); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o); // R5
  AST_MISUSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cpu_wr_i && !cs_n_o) |=> misuse_o); // R8
endmodule

// File: tb/spi_txdma_master_tb_top.sv
module spi_txdma_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i = 1'b0;
  logic [15:0] count_i = '0;
  logic [7:0]  div_i = '0;
  logic        dma_req_o, dma_ack_i = 1'b0;
  logic [15:0] dma_data_i = '0;
  logic        cpu_wr_i = 1'b0;
  logic        misuse_o, sclk_o, mosi_o, cs_n_o, done_o;

  always #10 clk = ~clk;

  spi_txdma_master dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
    .div_i(div_i), .dma_req_o(dma_req_o), .dma_ack_i(dma_ack_i),
    .dma_data_i(dma_data_i), .cpu_wr_i(cpu_wr_i), .misuse_o(misuse_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .cs_n_o(cs_n_o), .done_o(done_o)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit model_on = 0;
  // commands from the scenario process
  bit cmd_start = 0, cmd_wr = 0;
  int cmd_count = 0, cmd_div = 0, ack_per = 1;
  // reference model state
  bit m_sess = 0, exp_done = 0, prev_sclk = 0, prev_wr = 0, prev_cs_low = 0;
  int m_rem = 0, m_div = 0, pushed = 0, received = 0, done_obs = 0;
  int bits_rx = 0, hi_cnt = 0;
  logic [15:0] shreg_rx = '0, mem_word = 16'hA5C3;
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(negedge clk) begin
    bit was_sess;
    cyc++;
    if (cyc > 150000) begin
      chk(0, "WATCHDOG", "run exceeded cycle budget", cyc, 150000);
      finish_run();
    end
    if (model_on) begin
      hi_cnt++;
      // observe serial line
      if (!prev_sclk && sclk_o) begin
        shreg_rx = {shreg_rx[14:0], mosi_o};
        bits_rx++;
        hi_cnt = 0;
      end else if (prev_sclk && !sclk_o) begin
        chk(hi_cnt == m_div + 1, "R3", "SCLK high phase length", hi_cnt, m_div + 1);
        if (bits_rx == 16) begin
          received++;
          bits_rx = 0;
          if (exp_q.size() == 0)
            chk(0, "R3", "word sent that was never accepted", shreg_rx, 0);
          else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(shreg_rx == e, "R3", "serial word value", shreg_rx, e);
          end
        end
      end
      prev_sclk = sclk_o;
      if (done_o) done_obs++;
      // per-clock comparisons
      if (m_sess && m_rem > 0 && (pushed - received) <= 3)
        chk(dma_req_o == 1'b1, "R1", "request with FIFO room", dma_req_o, 1);
      if (!m_sess || m_rem == 0)
        chk(dma_req_o == 1'b0, "R2", "request after count used", dma_req_o, 0);
      if (pushed == received)
        chk(sclk_o == 1'b0, "R4", "SCLK idle with nothing queued", sclk_o, 0);
      chk(cs_n_o == !m_sess, "R5", "chip select", cs_n_o, !m_sess);
      chk(done_o == exp_done, "R5", "done pulse", done_o, exp_done);
      chk(misuse_o == (prev_wr && prev_cs_low), "R8", "misuse flag",
          misuse_o, prev_wr && prev_cs_low);
      // advance model
      was_sess = m_sess;
      exp_done = m_sess && m_rem == 0 && pushed == received;
      if (exp_done) m_sess = 0;
      // drive inputs for the next edge
      start_i = 1'b0;
      if (cmd_start) begin
        cmd_start = 0;
        start_i = 1'b1;
        count_i = 16'(cmd_count);
        div_i = 8'(cmd_div);
        if (!was_sess && cmd_count != 0) begin
          m_sess = 1; m_rem = cmd_count; m_div = cmd_div;
        end
      end
      dma_ack_i = (cyc % ack_per) == 0;
      dma_data_i = mem_word;
      if (dma_req_o && dma_ack_i) begin
        pushed++;
        m_rem--;
        exp_q.push_back(mem_word);
        mem_word = {mem_word[14:0], mem_word[15] ^ mem_word[12]} ^ 16'h1357;
      end
      cpu_wr_i = cmd_wr;
      cmd_wr = 0;
      prev_wr = cpu_wr_i;
      prev_cs_low = !cs_n_o;
    end
  end

  task automatic run_session(input int cnt, input int dv, input int ap,
                             input int wr_at, input int restart_at);
    int d0, p0;
    d0 = done_obs; p0 = pushed;
    @(posedge clk);
    ack_per = ap; cmd_div = dv; cmd_count = cnt; cmd_start = 1;
    for (int i = 0; i < 20000 && done_obs == d0; i++) begin
      @(posedge clk);
      if (i == wr_at) cmd_wr = 1;
      if (i == restart_at) begin
        cmd_count = 7; cmd_div = dv + 2; cmd_start = 1;
      end
    end
    repeat (3) @(posedge clk);
    chk(done_obs == d0 + 1, "R5", "one done per session", done_obs - d0, 1);
    chk(pushed - p0 == cnt, "R2", "words accepted per session", pushed - p0, cnt);
    chk(received == pushed, "R3", "all accepted words sent", received, pushed);
  endtask

  initial begin
    int p0, d0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R5", "reset chip select", cs_n_o, 1);
    chk(sclk_o == 1'b0, "R4", "reset SCLK", sclk_o, 0);
    chk(dma_req_o == 1'b0, "R1", "reset request", dma_req_o, 0);
    chk(done_o == 1'b0 && misuse_o == 1'b0, "R5", "reset pulses", done_o, 0);
    @(posedge clk);
    model_on = 1;
    // R1/R3: fast DMA, smallest divider, FIFO fills
    run_session(5, 0, 1, -1, -1);
    // R8: misuse during slow acknowledge session, then write while idle
    run_session(3, 2, 7, 10, -1);
    @(posedge clk); cmd_wr = 1;
    repeat (4) @(posedge clk);
    // R6: zero count
    p0 = pushed; d0 = done_obs;
    @(posedge clk); ack_per = 1; cmd_count = 0; cmd_div = 1; cmd_start = 1;
    repeat (40) @(posedge clk);
    chk(pushed == p0, "R6", "no words fetched for zero count", pushed - p0, 0);
    chk(cs_n_o == 1'b1, "R6", "chip select stays high", cs_n_o, 1);
    chk(done_obs == d0, "R6", "no done for zero count", done_obs - d0, 0);
    // R7: restart while active is ignored (count and divider kept)
    run_session(2, 1, 1, -1, 5);
    // R4: starved FIFO, words trickle in
    run_session(6, 0, 60, -1, -1);
    // R1: long burst with slow SCLK keeps FIFO full
    run_session(9, 3, 1, -1, -1);
    // single word session
    run_session(1, 5, 3, 20, -1);
    finish_run();
  end
endmodule